// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a serial port. A byte-wide bus reaches a 64-byte window in which the low six address bits pick one of several word-aligned registers: two mode bytes behind an auto-advancing pointer, a status byte, an interrupt status and mask pair, two read-only baud divisor bytes, and the transmit and receive data port. A single packed command byte carries three independent actions that all take effect on the same write: a miscellaneous action, a transmitter action and a receiver action.

Transmit bytes leave on a valid/ready byte stream. `tx_valid` is high while the transmitter is enabled and a byte is held. Once raised, it stays high with `tx_data` unchanged until `tx_ready` is seen, unless a command disables or resets the transmitter. A buffer write made while a byte is waiting and the handshake is not completing in that cycle is dropped. A write made in the cycle the handshake completes is kept. The receive FIFO sits outside this block. It supplies a not-empty flag, a full flag and the byte at its head, and it gets back a one-cycle pop, a flush pulse and the receiver enable level. A break-change event input sets an interrupt flag. One level interrupt output combines the interrupt status with the mask.

Top module: `uart_regfile`

## Requirements
- R1: Reads decode the low six address bits: 0x00 gives the selected mode byte, 0x04 the status, 0x0C the receive data, 0x14 the interrupt status, 0x18 and 0x1C the parameter baud bytes DIV_A and DIV_B, and every other offset, 0x08 included, reads 0. A write to 0x04 changes nothing.
- R2: The mode pointer starts at mode byte 1. A write to 0x00 stores into the selected byte and then points at mode byte 2, so later writes go to byte 2. Reads do not move the pointer.
- R3: The status bits are: bit 0 FIFO not empty, bit 1 FIFO full, bit 2 transmitter enabled, bit 3 transmitter empty, bits 7:4 zero.
- R4: Command bits 6:4 select the miscellaneous action. 1 points the mode pointer back at byte 1. 2 disables the receiver and pulses `rxq_flush` for one cycle. 3 disables the transmitter and marks it empty, which discards any held byte. 5 clears the break flag. Every other value does nothing.
- R5: Command bits 3:2 control the transmitter and bits 1:0 control the receiver: 1 enables, 2 disables, and 3 is ignored. These fields act after the miscellaneous action of the same write, so the command 0x34 leaves the transmitter enabled and the command 0x21 leaves the receiver enabled.
- R6: A write to 0x0C stores the byte and clears transmitter empty. While the transmitter is enabled the byte is offered on `tx_valid`/`tx_data`. Transmitter empty becomes 1 again only at the handshake, or on a transmitter reset.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and a buffer write is dropped. The command byte is the only thing that can withdraw `tx_valid`.
- R8: Interrupt status bit 0 equals transmitter enabled. Bit 1 equals FIFO full when mode byte 1 bit 6 is 1, and FIFO not empty otherwise. Bit 2 is the break flag. Bits 7:3 are zero.
- R9: `irq` is high exactly when the interrupt status ANDed with the mask written at 0x14 is nonzero.
- R10: A read of 0x0C while the FIFO is not empty returns `rxq_data` and raises `rxq_pop` in that cycle. When the FIFO is empty the read returns 0 and raises no pop.
- R11: A one-cycle `brk_evt` pulse sets the break flag, and the flag holds until command action 5. When the two arrive in the same cycle, the set wins.
- R12: After reset both mode bytes, the mask, the break flag and both enables are 0, the pointer selects byte 1, and the status reads 0x08 while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit byte taken |
| tx_data | output | 8 | Transmit byte |
| rxq_nonempty | input | 1 | Receive FIFO holds data |
| rxq_full | input | 1 | Receive FIFO full |
| rxq_data | input | 8 | Byte at the FIFO head |
| rxq_pop | output | 1 | Remove the head byte |
| rxq_flush | output | 1 | Empty the FIFO |
| rx_en | output | 1 | Receiver enabled |
| brk_evt | input | 1 | Break change seen |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a transmit buffer write that lands while a byte is stalled. To get there, the bench holds `tx_ready` low, writes a byte, writes a second byte while `tx_valid` is high, and then releases `tx_ready`. The scoreboard must then see only the first byte. A second hard case is a transmitter reset that lands on a stalled byte: the bench keeps `tx_ready` high afterwards, so any stray handshake shows up as an unexpected item. The bench also drives the FIFO flags to move the receive interrupt source between its two choices by rewriting mode byte 1 after a pointer reset.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_INT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_DIVA = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DIVB = 6'h1C;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_byte,
  output cmd_act_t      act
);
  always_comb begin
    act = '0;
    if (cmd_wr) begin
      case (misc_e'(cmd_byte[6:4]))
        MISC_PTR_RST: act.ptr_rst = 1'b1;
        MISC_RX_RST:  act.rx_rst  = 1'b1;
        MISC_TX_RST:  act.tx_rst  = 1'b1;
        MISC_BRK_CLR: act.brk_clr = 1'b1;
        default: ;
      endcase
      case (cmd_byte[3:2])
        2'd1: act.tx_on  = 1'b1;
        2'd2: act.tx_off = 1'b1;
        default: ;
      endcase
      case (cmd_byte[1:0])
        2'd1: act.rx_on  = 1'b1;
        2'd2: act.rx_off = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_data,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          flush,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_en,
  output logic          tx_empty
);
  logic [DW-1:0] hold_q;
  logic          fire;
  logic          accept;

  assign tx_valid = tx_en & ~tx_empty;
  assign tx_data  = hold_q;
  assign fire     = tx_valid & tx_ready;
  assign accept   = buf_wr & (~tx_valid | fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tx_empty <= 1'b1;
      tx_en    <= 1'b0;
    end else begin
      if (accept) begin
        hold_q   <= buf_data;
        tx_empty <= 1'b0;
      end else if (fire || flush) begin
        tx_empty <= 1'b1;
      end
      if (en_set)      tx_en <= 1'b1;
      else if (en_clr) tx_en <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_data,
  input  logic          brk_evt,
  input  logic          brk_clr,
  input  logic          tx_rdy,
  input  logic          rx_rdy,
  input  logic          fifo_full,
  input  logic          src_full,
  output logic [DW-1:0] isr,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_data;
      if (brk_evt)      brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;
    end
  end

  always_comb begin
    isr    = '0;
    isr[0] = tx_rdy;
    isr[1] = src_full ? fifo_full : rx_rdy;
    isr[2] = brk_q;
  end

  assign irq = |(isr & mask_q);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int          DW    = 8,
  parameter logic [7:0]  DIV_A = 8'hA5,
  parameter logic [7:0]  DIV_B = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  input  logic              rxq_nonempty,
  input  logic              rxq_full,
  input  logic [DW-1:0]     rxq_data,
  output logic              rxq_pop,
  output logic              rxq_flush,
  output logic              rx_en,
  input  logic              brk_evt,
  output logic              irq
);
  localparam int NUM_MODE = 2;
  localparam int SRC_BIT  = 6;

  logic [DW-1:0] mode_q [NUM_MODE];
  logic          mode_ptr;
  logic          wr_mode, wr_cmd, wr_data, wr_int, rd_data;
  cmd_act_t      act;
  logic          tx_en, tx_empty;
  logic [DW-1:0] isr, mask_q, status;

  assign wr_mode = bus_sel & bus_wr & (bus_addr == OFF_MODE);
  assign wr_cmd  = bus_sel & bus_wr & (bus_addr == OFF_CMD);
  assign wr_data = bus_sel & bus_wr & (bus_addr == OFF_DATA);
  assign wr_int  = bus_sel & bus_wr & (bus_addr == OFF_INT);
  assign rd_data = bus_sel & ~bus_wr & (bus_addr == OFF_DATA);

  uart_cmd_decode #(.DW(DW)) u_dec (
    .cmd_wr(wr_cmd), .cmd_byte(bus_wdata), .act(act)
  );

  uart_tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .buf_wr(wr_data), .buf_data(bus_wdata),
    .en_set(act.tx_on), .en_clr(act.tx_off | act.tx_rst), .flush(act.tx_rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_en(tx_en), .tx_empty(tx_empty)
  );

  uart_irq_unit #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(wr_int), .mask_data(bus_wdata),
    .brk_evt(brk_evt), .brk_clr(act.brk_clr), .tx_rdy(tx_en),
    .rx_rdy(rxq_nonempty), .fifo_full(rxq_full), .src_full(mode_q[0][SRC_BIT]),
    .isr(isr), .mask_q(mask_q), .irq(irq)
  );

  generate
    for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mode_q[g] <= '0;
        else if (wr_mode && (mode_ptr == 1'(g))) mode_q[g] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ptr <= 1'b0;
      rx_en    <= 1'b0;
    end else begin
      if (wr_mode)          mode_ptr <= 1'b1;
      else if (act.ptr_rst) mode_ptr <= 1'b0;
      if (act.rx_on)                   rx_en <= 1'b1;
      else if (act.rx_off || act.rx_rst) rx_en <= 1'b0;
    end
  end

  always_comb begin
    status    = '0;
    status[0] = rxq_nonempty;
    status[1] = rxq_full;
    status[2] = tx_en;
    status[3] = tx_empty;
  end

  assign rxq_pop   = rd_data & rxq_nonempty;
  assign rxq_flush = act.rx_rst;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_MODE: bus_rdata = mode_q[mode_ptr];
        OFF_STAT: bus_rdata = status;
        OFF_DATA: bus_rdata = rxq_nonempty ? rxq_data : '0;
        OFF_INT:  bus_rdata = isr;
        OFF_DIVA: bus_rdata = DW'(DIV_A);
        OFF_DIVB: bus_rdata = DW'(DIV_B);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_empty,
  input logic          rxq_nonempty,
  input logic          rxq_pop,
  input logic          mode_ptr,
  input logic [DW-1:0] mask_q,
  input logic          irq
);
  logic cmd_wr;
  assign cmd_wr = bus_sel && bus_wr && (bus_addr == 6'h08);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cmd_wr) |=> (tx_valid && $stable(tx_data)));

  assert_empty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(tx_valid && tx_ready) || $past(cmd_wr));

  assert_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> (rxq_nonempty && bus_sel && !bus_wr && bus_addr == 6'h0C));

  assert_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 6'h00) |=> mode_ptr);

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind uart_regfile uart_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_empty(tx_empty), .rxq_nonempty(rxq_nonempty),
  .rxq_pop(rxq_pop), .mode_ptr(mode_ptr), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_uart_regfile.sv
`timescale 1ns/1ps
module sim_uart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic       rxq_nonempty = 0, rxq_full = 0;
  logic [7:0] rxq_data = 0;
  logic       rxq_pop, rxq_flush, rx_en, brk_evt = 0, irq;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic       last_flush, last_pop;
  logic [7:0] rv;
  bit         done = 0;

  always #10 clk = ~clk;

  uart_regfile u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    #2 last_flush = rxq_flush;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata; last_pop = rxq_pop;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic send(logic [7:0] d);
    exp_q.push_back(d);
    wr(6'h0C, d);
  endtask

  always @(negedge clk) begin
    #3;
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected tx byte", tx_data, 8'hxx);
      end else begin
        chk("R6 tx byte", tx_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd(6'h04, rv); chk("R12 status", rv, 8'h08);
    rd(6'h00, rv); chk("R12 mode1", rv, 8'h00);
    chk("R12 irq", {7'b0, irq}, 8'h00);
    chk("R12 rx_en", {7'b0, rx_en}, 8'h00);
    // R2 mode pointer
    wr(6'h00, 8'h11); wr(6'h00, 8'h22); wr(6'h00, 8'h33);
    rd(6'h00, rv); chk("R2 mode2 after writes", rv, 8'h33);
    rd(6'h00, rv); chk("R2 read keeps pointer", rv, 8'h33);
    wr(6'h08, 8'h10);
    rd(6'h00, rv); chk("R4 ptr reset to mode1", rv, 8'h11);
    // R1 decode
    rd(6'h18, rv); chk("R1 div A", rv, 8'hA5);
    rd(6'h1C, rv); chk("R1 div B", rv, 8'h5A);
    rd(6'h10, rv); chk("R1 unmapped 0x10", rv, 8'h00);
    rd(6'h08, rv); chk("R1 cmd reads 0", rv, 8'h00);
    rd(6'h3C, rv); chk("R1 unmapped 0x3C", rv, 8'h00);
    wr(6'h04, 8'hFF);
    rd(6'h04, rv); chk("R1 status write ignored", rv, 8'h08);
    // R6 send while disabled, then enable
    tx_ready = 1;
    send(8'h41);
    rd(6'h04, rv); chk("R6 empty cleared", rv, 8'h00);
    chk("R6 no valid while disabled", {7'b0, tx_valid}, 8'h00);
    wr(6'h08, 8'h04);
    repeat (2) @(negedge clk);
    rd(6'h04, rv); chk("R6 empty after handshake", rv, 8'h0C);
    // R7 back-pressure
    @(negedge clk); tx_ready = 0;
    send(8'h42);
    wr(6'h0C, 8'h43);
    chk("R7 data held", tx_data, 8'h42);
    rd(6'h04, rv); chk("R7 status stalled", rv, 8'h04);
    @(negedge clk); tx_ready = 1;
    repeat (3) @(negedge clk);
    rd(6'h04, rv); chk("R7 empty after release", rv, 8'h0C);
    // R4 transmitter reset on a stalled byte
    @(negedge clk); tx_ready = 0;
    wr(6'h0C, 8'h44);
    wr(6'h08, 8'h30);
    rd(6'h04, rv); chk("R4 tx reset status", rv, 8'h08);
    @(negedge clk); tx_ready = 1;
    repeat (3) @(negedge clk);
    chk("R4 valid dropped", {7'b0, tx_valid}, 8'h00);
    // R5 combined and reserved fields
    wr(6'h08, 8'h34);
    rd(6'h04, rv); chk("R5 misc3 then enable", rv, 8'h0C);
    wr(6'h08, 8'h0C);
    rd(6'h04, rv); chk("R5 tx reserved ignored", rv, 8'h0C);
    wr(6'h08, 8'h38);
    rd(6'h04, rv); chk("R5 misc3 and disable", rv, 8'h08);
    wr(6'h08, 8'h01); chk("R5 rx enable", {7'b0, rx_en}, 8'h01);
    wr(6'h08, 8'h03); chk("R5 rx reserved ignored", {7'b0, rx_en}, 8'h01);
    wr(6'h08, 8'h02); chk("R5 rx disable", {7'b0, rx_en}, 8'h00);
    // R9 interrupt mask with transmitter ready
    wr(6'h08, 8'h04);
    wr(6'h14, 8'h01);
    chk("R9 irq on tx ready", {7'b0, irq}, 8'h01);
    rd(6'h14, rv); chk("R8 isr tx bit", rv, 8'h01);
    wr(6'h14, 8'h00);
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    wr(6'h08, 8'h08);
    // R8 / R10 receive side
    @(negedge clk); rxq_nonempty = 1; rxq_data = 8'h5A;
    rd(6'h04, rv); chk("R3 status rx ready", rv, 8'h09);
    rd(6'h14, rv); chk("R8 isr rx ready source", rv, 8'h02);
    rd(6'h0C, rv); chk("R10 rx data", rv, 8'h5A);
    chk("R10 pop on read", {7'b0, last_pop}, 8'h01);
    wr(6'h08, 8'h10); wr(6'h00, 8'h40);
    rd(6'h14, rv); chk("R8 full source not full", rv, 8'h00);
    @(negedge clk); rxq_full = 1;
    rd(6'h14, rv); chk("R8 full source full", rv, 8'h02);
    rd(6'h04, rv); chk("R3 status full", rv, 8'h0B);
    @(negedge clk); rxq_full = 0; rxq_nonempty = 0;
    rd(6'h0C, rv); chk("R10 empty read zero", rv, 8'h00);
    chk("R10 no pop when empty", {7'b0, last_pop}, 8'h00);
    // R4 receiver reset
    wr(6'h08, 8'h21);
    chk("R4 flush pulse", {7'b0, last_flush}, 8'h01);
    chk("R5 rx field after misc2", {7'b0, rx_en}, 8'h01);
    wr(6'h08, 8'h20);
    chk("R4 rx disabled", {7'b0, rx_en}, 8'h00);
    wr(6'h08, 8'h00);
    chk("R4 nop no flush", {7'b0, last_flush}, 8'h00);
    // R11 break flag
    @(negedge clk); brk_evt = 1;
    @(negedge clk); brk_evt = 0;
    rd(6'h14, rv); chk("R11 break flag set", rv, 8'h04);
    wr(6'h14, 8'h04);
    chk("R11 break irq", {7'b0, irq}, 8'h01);
    wr(6'h08, 8'h40);
    rd(6'h14, rv); chk("R4 misc4 keeps flag", rv, 8'h04);
    wr(6'h08, 8'h50);
    rd(6'h14, rv); chk("R4 break clear", rv, 8'h00);
    chk("R9 irq after clear", {7'b0, irq}, 8'h00);
    repeat (4) @(negedge clk);
    chk("R6 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule